// File: doc/BRIEF.md
# NAND Bad Block Table Builder

This block builds, at power-up, a table holding one flag bit for each erase block of a serial NAND array. Once reset is released it walks the blocks in ascending order, one at a time. For each block it asks a command-sequencer port for a single byte: the first spare-area byte of page 0 of that block. Any value other than 0xFF marks the block as bad from the factory. If the sequencer reports an error for a block, that block is also flagged, and a sticky error output is raised.

After the scan, the table is the authority for block health. Firmware or a flash translation layer queries it through a one-cycle lookup port. Program and erase failures seen at run time are reported through a mark port, and each report sets the block's flag. A mark that arrives during the scan is held in a small queue. Held marks are written once the scan ends, and the table is declared ready only after every held mark has been applied. Lookups made before that point return a busy indication instead of a flag.

Top module: `bbt_builder`

## Requirements
- R1: After reset the block issues exactly one read request per erase block, in ascending index order starting at 0, with at most one read outstanding. Each request carries row = block index shifted left by log2(PAGES_PER_BLOCK), which addresses page 0, and column = MAIN_BYTES (2048 by default), the first spare byte. A request stays asserted with an unchanged row until `rd_req_ready` is seen high.
- R2: A block whose returned marker byte equals 0xFF is recorded good (flag 0). Any other byte value records it bad (flag 1).
- R3: A response with `rd_rsp_err` high records that block bad whatever the data, and sets `scan_error`, which stays high until reset.
- R4: In reset, `scan_done`, `scan_error`, `bad_count` and `rd_req_valid` are 0. `scan_done` rises only after the response for the last block has arrived and all held marks are applied, then stays high until reset. `bad_count` then equals the number of blocks the scan found bad (R2, R3).
- R5: A lookup (`lu_valid` high for one cycle) is answered in the next cycle with `lu_resp_valid` high. If `scan_done` was low in the lookup cycle, `lu_busy` is 1 and `lu_bad` is 0.
- R6: A lookup made while `scan_done` is high returns `lu_busy` = 0 and `lu_bad` equal to the table flag of `lu_block`.
- R7: A mark (`mark_valid` with `mark_block`) made while `scan_done` is high sets that block's flag. A lookup of the same block in the same cycle already returns 1. Other blocks are unaffected.
- R8: Marks made while `scan_done` is low are held and applied after the scan, before `scan_done` rises. A held mark is not lost when the scan later writes that block.
- R9: While `scan_done` is low, at most PEND_DEPTH marks are held. Any further mark in that period is ignored.
- R10: Flags are only ever set, never cleared. Marking an already-bad block leaves it bad, and marks never change `bad_count`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_req_valid | output | 1 | Read request to the sequencer |
| rd_req_ready | input | 1 | Sequencer accepts the request |
| rd_req_row | output | BLK_W+PAGE_W | Row (page) address of the request |
| rd_req_col | output | COL_W | Column (byte) address of the request |
| rd_rsp_valid | input | 1 | Response byte is valid |
| rd_rsp_data | input | 8 | Marker byte returned |
| rd_rsp_err | input | 1 | Sequencer failed this read |
| mark_valid | input | 1 | Runtime failure report |
| mark_block | input | BLK_W | Block that failed program or erase |
| lu_valid | input | 1 | Lookup request |
| lu_block | input | BLK_W | Block to look up |
| lu_resp_valid | output | 1 | Lookup answer valid |
| lu_busy | output | 1 | Table not ready when lookup was made |
| lu_bad | output | 1 | Block flag (1 = bad) |
| scan_done | output | 1 | Table built and held marks applied |
| scan_error | output | 1 | Sticky: a scan read failed |
| bad_count | output | CNT_W | Blocks found bad by the scan |

## Verification
Two pairs of functions can land in the same cycle, and the bench provokes both.

The first pair is a runtime mark and a lookup after the scan. The bench drives a mark and a lookup of the same block in one cycle and expects the lookup to report the block bad at once. It then repeats the pair with two different blocks and expects the looked-up block to stay good.

The second pair is a held mark and the scan's own write to the same block. The bench marks blocks during the scan, both ahead of the scan position and on blocks that are bad from the factory. After the scan it sweeps every block against a table computed from the marker pattern, the injected errors and the mark list. It also checks that the fifth held mark was dropped and that `bad_count` ignores the marks.

// File: rtl/bbt_pkg.sv
// Package: shared types and helpers for the bad block table builder.
// Assumes: the factory good marker value is all ones.
package bbt_pkg;

    // Scan sequencing states.
    typedef enum logic [1:0] {
        SC_IDLE = 2'd0,
        SC_REQ  = 2'd1,
        SC_WAIT = 2'd2,
        SC_FIN  = 2'd3
    } scan_state_t;

    localparam logic [7:0] GOOD_MARK = 8'hFF;

    // A block is bad when the read failed or the marker is not the good value.
    function automatic logic marker_is_bad(input logic [7:0] mark, input logic err);
        return err || (mark != GOOD_MARK);
    endfunction

endpackage

// File: rtl/bbt_scan_ctrl.sv
// Module: bbt_scan_ctrl
// Walks all blocks in ascending order and requests one spare byte per block,
// with one read outstanding. It reports a table write for each bad block and
// keeps the sticky error flag and the bad block count.
// Assumes: the sequencer sends exactly one response per accepted request.
module bbt_scan_ctrl
    import bbt_pkg::*;
#(
    parameter int NUM_BLOCKS = 2048,
    parameter int PAGE_W     = 6,
    parameter int COL_W      = 12,
    parameter int MARK_COL   = 2048,
    localparam int BLK_W     = $clog2(NUM_BLOCKS),
    localparam int ROW_W     = BLK_W + PAGE_W,
    localparam int CNT_W     = $clog2(NUM_BLOCKS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic             req_valid,
    input  logic             req_ready,
    output logic [ROW_W-1:0] req_row,
    output logic [COL_W-1:0] req_col,
    input  logic             rsp_valid,
    input  logic [7:0]       rsp_data,
    input  logic             rsp_err,
    output logic             wr_en,
    output logic [BLK_W-1:0] wr_blk,
    output logic             scan_fin,
    output logic             scan_error,
    output logic [CNT_W-1:0] bad_count
);

    localparam logic [BLK_W-1:0] LAST_BLK = BLK_W'(NUM_BLOCKS - 1);

    scan_state_t      state_q, state_d;
    logic [BLK_W-1:0] blk_q;
    logic             rsp_bad;

    // Classify the response arriving for the current block.
    always_comb begin
        rsp_bad = marker_is_bad(rsp_data, rsp_err);
    end

    // Next-state selection of the scan sequence.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SC_IDLE: state_d = SC_REQ;
            SC_REQ:  if (req_ready) state_d = SC_WAIT;
            SC_WAIT: if (rsp_valid) state_d = (blk_q == LAST_BLK) ? SC_FIN : SC_REQ;
            SC_FIN:  state_d = SC_FIN;
            default: state_d = SC_IDLE;
        endcase
    end

    // State register and block index counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SC_IDLE;
            blk_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == SC_WAIT && rsp_valid && blk_q != LAST_BLK) begin
                blk_q <= blk_q + 1'b1;
            end
        end
    end

    // Sticky error flag and bad block counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scan_error <= 1'b0;
            bad_count  <= '0;
        end else if (state_q == SC_WAIT && rsp_valid) begin
            if (rsp_err) scan_error <= 1'b1;
            if (rsp_bad) bad_count <= bad_count + 1'b1;
        end
    end

    // Request and table-write outputs.
    always_comb begin
        req_valid = (state_q == SC_REQ);
        req_row   = {blk_q, {PAGE_W{1'b0}}};
        req_col   = COL_W'(MARK_COL);
        wr_en     = (state_q == SC_WAIT) && rsp_valid && rsp_bad;
        wr_blk    = blk_q;
        scan_fin  = (state_q == SC_FIN);
    end

endmodule

// File: rtl/bbt_pend_fifo.sv
// Module: bbt_pend_fifo
// Small FIFO that holds runtime marks while the scan runs.
// Assumes: the caller gates push with !full and pop with !empty.
module bbt_pend_fifo #(
    parameter int DEPTH  = 4,
    parameter int DATA_W = 11,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] head,
    output logic              empty,
    output logic              full
);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic [PTR_W:0]    count;

    // Advance a pointer, wrapping at DEPTH.
    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Storage write.
    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= push_data;
    end

    // Pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= ptr_next(wr_ptr);
            if (pop)  rd_ptr <= ptr_next(rd_ptr);
            count <= count + (PTR_W+1)'(push) - (PTR_W+1)'(pop);
        end
    end

    // Status and head of queue.
    always_comb begin
        head  = mem[rd_ptr];
        empty = (count == '0);
        full  = (count == (PTR_W+1)'(DEPTH));
    end

endmodule

// File: rtl/bbt_flag_table.sv
// Module: bbt_flag_table
// One flag bit per block, built from flops. The write port only sets bits.
// The read port is combinational.
// Assumes: NUM_BLOCKS is a power of two, so every index is in range.
module bbt_flag_table #(
    parameter int NUM_BLOCKS = 2048,
    localparam int BLK_W     = $clog2(NUM_BLOCKS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_en,
    input  logic [BLK_W-1:0] set_blk,
    input  logic [BLK_W-1:0] rd_blk,
    output logic             rd_flag
);

    logic [NUM_BLOCKS-1:0] flags;

    for (genvar g = 0; g < NUM_BLOCKS; g++) begin : g_flag
        // Set this block's flag when it is addressed.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                flags[g] <= 1'b0;
            end else if (set_en && set_blk == BLK_W'(g)) begin
                flags[g] <= 1'b1;
            end
        end
    end

    // Read the requested flag.
    always_comb begin
        rd_flag = flags[rd_blk];
    end

endmodule

// File: rtl/bbt_builder.sv
// Module: bbt_builder (top)
// Builds the bad block table by scanning the markers, holds runtime marks
// until the scan ends, and answers lookups one cycle after the request.
// Assumes: the sequencer handshake is as described for bbt_scan_ctrl, and
// NUM_BLOCKS is a power of two.
module bbt_builder #(
    parameter int NUM_BLOCKS      = 2048,
    parameter int PAGES_PER_BLOCK = 64,
    parameter int MAIN_BYTES      = 2048,
    parameter int SPARE_BYTES     = 64,
    parameter int PEND_DEPTH      = 4,
    localparam int BLK_W          = $clog2(NUM_BLOCKS),
    localparam int PAGE_W         = $clog2(PAGES_PER_BLOCK),
    localparam int ROW_W          = BLK_W + PAGE_W,
    localparam int COL_W          = $clog2(MAIN_BYTES + SPARE_BYTES),
    localparam int CNT_W          = $clog2(NUM_BLOCKS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic             rd_req_valid,
    input  logic             rd_req_ready,
    output logic [ROW_W-1:0] rd_req_row,
    output logic [COL_W-1:0] rd_req_col,
    input  logic             rd_rsp_valid,
    input  logic [7:0]       rd_rsp_data,
    input  logic             rd_rsp_err,
    input  logic             mark_valid,
    input  logic [BLK_W-1:0] mark_block,
    input  logic             lu_valid,
    input  logic [BLK_W-1:0] lu_block,
    output logic             lu_resp_valid,
    output logic             lu_busy,
    output logic             lu_bad,
    output logic             scan_done,
    output logic             scan_error,
    output logic [CNT_W-1:0] bad_count
);

    logic             scan_wr;
    logic [BLK_W-1:0] scan_blk;
    logic             scan_fin;
    logic             q_push, q_pop, q_empty, q_full;
    logic [BLK_W-1:0] q_head;
    logic             tbl_we;
    logic [BLK_W-1:0] tbl_wa;
    logic             tbl_rd;
    logic             direct_mark;

    bbt_scan_ctrl #(
        .NUM_BLOCKS(NUM_BLOCKS),
        .PAGE_W    (PAGE_W),
        .COL_W     (COL_W),
        .MARK_COL  (MAIN_BYTES)
    ) u_scan (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (rd_req_valid),
        .req_ready (rd_req_ready),
        .req_row   (rd_req_row),
        .req_col   (rd_req_col),
        .rsp_valid (rd_rsp_valid),
        .rsp_data  (rd_rsp_data),
        .rsp_err   (rd_rsp_err),
        .wr_en     (scan_wr),
        .wr_blk    (scan_blk),
        .scan_fin  (scan_fin),
        .scan_error(scan_error),
        .bad_count (bad_count)
    );

    bbt_pend_fifo #(
        .DEPTH (PEND_DEPTH),
        .DATA_W(BLK_W)
    ) u_pend (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (q_push),
        .push_data(mark_block),
        .pop      (q_pop),
        .head     (q_head),
        .empty    (q_empty),
        .full     (q_full)
    );

    bbt_flag_table #(
        .NUM_BLOCKS(NUM_BLOCKS)
    ) u_table (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_en (tbl_we),
        .set_blk(tbl_wa),
        .rd_blk (lu_block),
        .rd_flag(tbl_rd)
    );

    // Ready once the scan is finished and the held marks are drained.
    always_comb begin
        scan_done = scan_fin && q_empty;
    end

    // Route marks and choose the single table writer for this cycle.
    always_comb begin
        direct_mark = scan_done && mark_valid;
        q_push      = mark_valid && !scan_done && !q_full;
        q_pop       = scan_fin && !q_empty;
        tbl_we      = scan_wr || q_pop || direct_mark;
        if (scan_wr) begin
            tbl_wa = scan_blk;
        end else if (q_pop) begin
            tbl_wa = q_head;
        end else begin
            tbl_wa = mark_block;
        end
    end

    // Registered lookup answer; a write to the same block in the same cycle is forwarded.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lu_resp_valid <= 1'b0;
            lu_busy       <= 1'b0;
            lu_bad        <= 1'b0;
        end else begin
            lu_resp_valid <= lu_valid;
            lu_busy       <= lu_valid && !scan_done;
            lu_bad        <= lu_valid && scan_done &&
                             (tbl_rd || (tbl_we && tbl_wa == lu_block));
        end
    end

endmodule

// File: rtl/bbt_builder_chk.sv
// Module: bbt_builder_chk
// Assertion checker bound to bbt_builder. It tracks the outstanding read
// with its own flag.
module bbt_builder_chk #(
    parameter int NUM_BLOCKS = 2048,
    parameter int ROW_W      = 17,
    parameter int COL_W      = 12,
    parameter int MARK_COL   = 2048,
    parameter int CNT_W      = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rd_req_valid,
    input logic             rd_req_ready,
    input logic [ROW_W-1:0] rd_req_row,
    input logic [COL_W-1:0] rd_req_col,
    input logic             rd_rsp_valid,
    input logic             lu_resp_valid,
    input logic             lu_busy,
    input logic             lu_bad,
    input logic             scan_done,
    input logic             scan_error,
    input logic [CNT_W-1:0] bad_count
);

    logic outstanding;

    // Track whether an accepted read still awaits its response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            outstanding <= 1'b0;
        end else if (rd_req_valid && rd_req_ready) begin
            outstanding <= 1'b1;
        end else if (rd_rsp_valid) begin
            outstanding <= 1'b0;
        end
    end

    p_req_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_valid && !rd_req_ready |=> rd_req_valid && $stable(rd_req_row));

    p_spare_col_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_valid |-> rd_req_col == COL_W'(MARK_COL));

    p_single_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_valid |-> !outstanding);

    p_err_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        scan_error |=> scan_error);

    p_done_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        scan_done |=> scan_done);

    p_count_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bad_count <= CNT_W'(NUM_BLOCKS));

    p_no_reads_after_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
        scan_done |-> !rd_req_valid);

    p_busy_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
        lu_resp_valid |-> lu_busy == !$past(scan_done));

    p_busy_no_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        lu_busy |-> !lu_bad);

endmodule

bind bbt_builder bbt_builder_chk #(
    .NUM_BLOCKS(NUM_BLOCKS),
    .ROW_W     (ROW_W),
    .COL_W     (COL_W),
    .MARK_COL  (MAIN_BYTES),
    .CNT_W     (CNT_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .rd_req_valid (rd_req_valid),
    .rd_req_ready (rd_req_ready),
    .rd_req_row   (rd_req_row),
    .rd_req_col   (rd_req_col),
    .rd_rsp_valid (rd_rsp_valid),
    .lu_resp_valid(lu_resp_valid),
    .lu_busy      (lu_busy),
    .lu_bad       (lu_bad),
    .scan_done    (scan_done),
    .scan_error   (scan_error),
    .bad_count    (bad_count)
);

// File: tb/tb_bbt_builder.sv
// Bench for bbt_builder on a 32-block array: a sequencer model with varying
// latencies, held marks during the scan, a full lookup sweep and
// same-cycle mark/lookup cases.
module tb_bbt_builder;

    localparam int NB    = 32;
    localparam int PPB   = 64;
    localparam int MAINB = 2048;
    localparam int BLK_W = $clog2(NB);
    localparam int PG_W  = $clog2(PPB);
    localparam int ROW_W = BLK_W + PG_W;
    localparam int COL_W = $clog2(MAINB + 64);
    localparam int CNT_W = $clog2(NB + 1);

    logic             clk = 1'b0;
    logic             rst_n;
    logic             rd_req_valid, rd_req_ready;
    logic [ROW_W-1:0] rd_req_row;
    logic [COL_W-1:0] rd_req_col;
    logic             rd_rsp_valid, rd_rsp_err;
    logic [7:0]       rd_rsp_data;
    logic             mark_valid, lu_valid;
    logic [BLK_W-1:0] mark_block, lu_block;
    logic             lu_resp_valid, lu_busy, lu_bad;
    logic             scan_done, scan_error;
    logic [CNT_W-1:0] bad_count;

    int n_checks = 0;
    int n_fails  = 0;
    int rsp_seen = 0;

    always #10 clk = ~clk;

    bbt_builder #(
        .NUM_BLOCKS     (NB),
        .PAGES_PER_BLOCK(PPB),
        .MAIN_BYTES     (MAINB),
        .SPARE_BYTES    (64),
        .PEND_DEPTH     (4)
    ) dut (
        .clk(clk), .rst_n(rst_n),
        .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
        .rd_req_row(rd_req_row), .rd_req_col(rd_req_col),
        .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data), .rd_rsp_err(rd_rsp_err),
        .mark_valid(mark_valid), .mark_block(mark_block),
        .lu_valid(lu_valid), .lu_block(lu_block),
        .lu_resp_valid(lu_resp_valid), .lu_busy(lu_busy), .lu_bad(lu_bad),
        .scan_done(scan_done), .scan_error(scan_error), .bad_count(bad_count)
    );

    // Marker byte stored in the model for block b.
    function automatic logic [7:0] marker(input int b);
        if (b % 5 == 3) return (b % 2 == 1) ? 8'h00 : 8'hFE;
        return 8'hFF;
    endfunction

    // Blocks whose read the model fails.
    function automatic bit seq_err(input int b);
        return (b == 17) || (b == 30);
    endfunction

    // Blocks marked during the scan and expected to be held.
    function automatic bit held_mark(input int b);
        return (b == 1) || (b == 3) || (b == 10) || (b == 20);
    endfunction

    task automatic check(input bit ok, input string what, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    // Lookup, optionally with a mark in the same cycle; sample after the response edge.
    task automatic lookup(input int b, input bit with_mark, input int mb,
                          output bit busy, output bit bad, output bit vld);
        @(negedge clk);
        lu_valid = 1'b1;
        lu_block = BLK_W'(b);
        if (with_mark) begin
            mark_valid = 1'b1;
            mark_block = BLK_W'(mb);
        end
        @(negedge clk);
        lu_valid   = 1'b0;
        mark_valid = 1'b0;
        busy = lu_busy;
        bad  = lu_bad;
        vld  = lu_resp_valid;
    endtask

    task automatic mark(input int b);
        @(negedge clk);
        mark_valid = 1'b1;
        mark_block = BLK_W'(b);
        @(negedge clk);
        mark_valid = 1'b0;
    endtask

    // Sequencer model: checks each request, then answers with block-dependent latency.
    initial begin
        int exp_blk;
        logic [ROW_W-1:0] held_row;
        exp_blk = 0;
        rd_req_ready = 1'b0;
        rd_rsp_valid = 1'b0;
        rd_rsp_data  = 8'h00;
        rd_rsp_err   = 1'b0;
        forever begin
            @(negedge clk);
            if (rst_n && rd_req_valid) begin
                held_row = rd_req_row;
                check(int'(rd_req_row) == (exp_blk << PG_W),
                      "R1 request row order", int'(rd_req_row), exp_blk << PG_W);
                check(int'(rd_req_col) == MAINB, "R1 request column",
                      int'(rd_req_col), MAINB);
                for (int w = 0; w < exp_blk % 3; w++) begin
                    @(negedge clk);
                    check(rd_req_valid && rd_req_row == held_row, "R1 request held",
                          int'(rd_req_row), int'(held_row));
                end
                rd_req_ready = 1'b1;
                @(negedge clk);
                rd_req_ready = 1'b0;
                for (int w = 0; w < exp_blk % 4; w++) @(negedge clk);
                rd_rsp_valid = 1'b1;
                rd_rsp_data  = marker(exp_blk);
                rd_rsp_err   = seq_err(exp_blk);
                @(negedge clk);
                rd_rsp_valid = 1'b0;
                rd_rsp_err   = 1'b0;
                rsp_seen++;
                exp_blk++;
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        bit busy, bad, vld;
        int exp_count;
        rst_n      = 1'b0;
        mark_valid = 1'b0;
        mark_block = '0;
        lu_valid   = 1'b0;
        lu_block   = '0;
        repeat (3) @(negedge clk);
        check(!scan_done, "R4 reset scan_done", int'(scan_done), 0);
        check(!scan_error, "R4 reset scan_error", int'(scan_error), 0);
        check(bad_count == 0, "R4 reset bad_count", int'(bad_count), 0);
        check(!rd_req_valid, "R4 reset request", int'(rd_req_valid), 0);
        rst_n = 1'b1;

        // R5: lookup while the scan runs.
        lookup(5, 1'b0, 0, busy, bad, vld);
        check(vld, "R5 response valid", int'(vld), 1);
        check(busy, "R5 busy during scan", int'(busy), 1);
        check(!bad, "R5 no flag while busy", int'(bad), 0);

        // R8: held marks, including a factory-bad block; R9: fifth one dropped.
        mark(1); mark(3); mark(10); mark(20); mark(22);

        while (!scan_done) @(negedge clk);
        check(rsp_seen == NB, "R4 done after last response", rsp_seen, NB);
        exp_count = 0;
        for (int b = 0; b < NB; b++) begin
            if (marker(b) != 8'hFF || seq_err(b)) exp_count++;
        end
        check(int'(bad_count) == exp_count, "R4 bad_count", int'(bad_count), exp_count);
        check(scan_error, "R3 scan_error sticky", int'(scan_error), 1);

        // R6 sweep: every block against the computed table (R2, R3, R8, R9).
        for (int b = 0; b < NB; b++) begin
            bit exp_bad;
            exp_bad = (marker(b) != 8'hFF) || seq_err(b) || held_mark(b);
            lookup(b, 1'b0, 0, busy, bad, vld);
            check(vld && !busy, "R6 lookup ready", int'(busy), 0);
            check(bad == exp_bad, $sformatf("R6 flag block %0d (R2 R3 R8 R9)", b),
                  int'(bad), int'(exp_bad));
        end

        // R7: mark and lookup of the same block in one cycle.
        lookup(0, 1'b1, 0, busy, bad, vld);
        check(bad, "R7 same-cycle forward", int'(bad), 1);
        lookup(0, 1'b0, 0, busy, bad, vld);
        check(bad, "R7 mark kept", int'(bad), 1);
        // R7: mark one block while looking up another.
        lookup(2, 1'b1, 4, busy, bad, vld);
        check(!bad, "R7 other block unaffected", int'(bad), 0);
        lookup(4, 1'b0, 0, busy, bad, vld);
        check(bad, "R7 marked block set", int'(bad), 1);

        // R10: re-mark a bad block; count unchanged.
        mark(3);
        lookup(3, 1'b0, 0, busy, bad, vld);
        check(bad, "R10 bad stays bad", int'(bad), 1);
        check(int'(bad_count) == exp_count, "R10 count ignores marks",
              int'(bad_count), exp_count);
        lookup(22, 1'b0, 0, busy, bad, vld);
        check(!bad, "R9 dropped mark absent", int'(bad), 0);
        check(scan_done, "R4 scan_done holds", int'(scan_done), 1);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule